// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block times the clock line of an I2C master from the peripheral clock. A waveform configuration word carries separate dividers for the low and high halves of SCL and one shared power-of-two prescaler. Each half lasts its divider shifted left by the prescaler, plus a fixed offset of a few clocks that is set at build time. With equal dividers, the bus clock is the input clock divided by twice the length of one half.

The generator also produces two single-cycle timing strobes for the master's bit engine. The first, early in the low half, marks where SDA may change. The second, at the middle of the high half, marks where SDA should be sampled. The configuration word is taken into a shadow copy only at phase boundaries, so rewriting it never shortens or stretches the phase in progress. While disabled, SCL is released high and nothing counts.

Top module: `sclgen_top`

## Requirements
- R1: A low phase lasts exactly (lo_div << p) + OFFSET input clocks. p is the effective prescaler and OFFSET is a build parameter (default 4).
- R2: A high phase lasts exactly (hi_div << p) + OFFSET input clocks. Low and high phases alternate.
- R3: The configuration word `wave_cfg` is decoded as follows: the prescaler is in bits [18:16], hi_div in bits [15:8] and lo_div in bits [7:0].
- R4: The effective prescaler p is the prescaler field, saturated at the parameter PRE_MAX (default 5). For example, a field value of 7 acts as 5.
- R5: When `en` is first sampled high, SCL goes low in the next cycle and stays low for one full low phase.
- R6: A configuration change takes effect only at the next phase boundary. The phase already in progress keeps the length it had when it started.
- R7: While `en` is low, SCL is high and neither strobe fires from the cycle after `en` is sampled low. The phase counter is held at zero, so re-enabling starts a fresh full low phase.
- R8: `drive_stb` is high for exactly one cycle in each low phase, at cycle index 1 counted from the first low cycle (index 0). It never fires in a high phase.
- R9: `sample_stb` is high for exactly one cycle in each high phase, at cycle index floor(L/2), where L is that phase's length. It never fires in a low phase.
- R10: While `rst` is held, SCL is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| wave_cfg | input | 19 | Waveform configuration: prescaler, high divider, low divider |
| scl_o | output | 1 | SCL level request (1 = release high, 0 = pull low) |
| sample_stb | output | 1 | SDA sample point, middle of high phase |
| drive_stb | output | 1 | SDA change point, early in low phase |

## Verification
The bench uses several divider patterns:
- Equal small dividers with no prescaling give a plain symmetric baseline.
- Strongly unequal dividers with a non-zero prescaler expose swapped fields or a wrong shift.
- Zero dividers reduce each phase to the bare offset and put the strobes at their tightest positions.
- A prescaler field above the limit shows whether saturation happens.
- A long low phase against a short high phase exercises the full counter width.

Two further scenarios cover the control behaviour. In one, the configuration is rewritten in the middle of a phase; this separates boundary-aligned loading from immediate loading. In the other, the block is disabled in the middle of a phase and then re-enabled, which shows whether the counter restarts from zero.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int DIV_W     = 8;
    localparam int PRE_W     = 3;
    localparam int CFG_W     = 2 * DIV_W + PRE_W;
    localparam int MAX_SHIFT = (1 << PRE_W) - 1;
    localparam int CNT_W     = DIV_W + MAX_SHIFT + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] hi;
        logic [DIV_W-1:0] lo;
    } wave_cfg_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    function automatic cnt_t phase_len(
        input logic [DIV_W-1:0] div,
        input logic [PRE_W-1:0] pre,
        input int unsigned      pre_max,
        input int unsigned      offset
    );
        logic [PRE_W-1:0] eff;
        cnt_t             base;
        eff  = (32'(pre) > pre_max) ? PRE_W'(pre_max) : pre;
        base = cnt_t'(div) << eff;
        return base + cnt_t'(offset);
    endfunction

endpackage

// File: rtl/sclgen_shadow.sv
module sclgen_shadow
    import sclgen_pkg::*;
#(
    parameter int unsigned PRE_MAX = 5,
    parameter int unsigned OFFSET  = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  wave_cfg_t cfg_in,
    input  phase_t    phase,
    output cnt_t      len_cur,
    output cnt_t      mid_hi
);

    wave_cfg_t cfg_q;
    cnt_t      len_lo;
    cnt_t      len_hi;

    // Shadow copy: updated only when idle or at a phase boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        len_lo  = phase_len(cfg_q.lo, cfg_q.pre, PRE_MAX, OFFSET);
        len_hi  = phase_len(cfg_q.hi, cfg_q.pre, PRE_MAX, OFFSET);
        len_cur = (phase == PH_HIGH) ? len_hi : len_lo;
        mid_hi  = len_hi >> 1;
    end

endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
    import sclgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  cnt_t   len_cur,
    output logic   active,
    output phase_t phase,
    output cnt_t   cnt,
    output logic   at_end
);

    assign at_end = active && (cnt == len_cur - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            cnt    <= '0;
            phase  <= PH_LOW;
        end else if (!active) begin
            active <= 1'b1;
            cnt    <= '0;
            phase  <= PH_LOW;
        end else if (at_end) begin
            cnt    <= '0;
            phase  <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            cnt    <= cnt + cnt_t'(1);
        end
    end

    // R1 R2: the counter never runs past the length of the phase it is timing
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < len_cur));

    // R2: a phase boundary toggles the level when the block stays enabled
    assert_flip_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        (en && at_end) |=> (phase != $past(phase)));

    // R7: disabling clears activity and holds the counter at zero
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!active && cnt == '0));

endmodule

// File: rtl/sclgen_strobe.sv
module sclgen_strobe
    import sclgen_pkg::*;
(
    input  logic   active,
    input  phase_t phase,
    input  cnt_t   cnt,
    input  cnt_t   mid_hi,
    output logic   scl,
    output logic   smp,
    output logic   drv
);

    always_comb begin
        scl = !(active && phase == PH_LOW);
        drv = active && (phase == PH_LOW)  && (cnt == cnt_t'(1));
        smp = active && (phase == PH_HIGH) && (cnt == mid_hi);
    end

endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
    import sclgen_pkg::*;
#(
    parameter int unsigned PRE_MAX = 5,
    parameter int unsigned OFFSET  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CFG_W-1:0] wave_cfg,
    output logic             scl_o,
    output logic             sample_stb,
    output logic             drive_stb
);

    wave_cfg_t cfg_s;
    phase_t    phase;
    cnt_t      cnt;
    cnt_t      len_cur;
    cnt_t      mid_hi;
    logic      active;
    logic      at_end;
    logic      load;

    assign cfg_s = wave_cfg_t'(wave_cfg);
    assign load  = !active || at_end;

    sclgen_shadow #(.PRE_MAX(PRE_MAX), .OFFSET(OFFSET)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_s),
        .phase   (phase),
        .len_cur (len_cur),
        .mid_hi  (mid_hi)
    );

    sclgen_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .len_cur (len_cur),
        .active  (active),
        .phase   (phase),
        .cnt     (cnt),
        .at_end  (at_end)
    );

    sclgen_strobe u_strobe (
        .active  (active),
        .phase   (phase),
        .cnt     (cnt),
        .mid_hi  (mid_hi),
        .scl     (scl_o),
        .smp     (sample_stb),
        .drv     (drive_stb)
    );

    // R6: the length in force cannot move while a phase is in progress
    assert_len_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !at_end && en) |=> $stable(len_cur));

    // R7: one cycle after enable is sampled low the line is released and quiet
    assert_idle_out_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl_o && !sample_stb && !drive_stb));

    // R8: the change strobe only occurs while SCL is held low
    assert_drv_low_R8: assert property (@(posedge clk) disable iff (rst)
        drive_stb |-> !scl_o);

    // R9: the sample strobe only occurs while SCL is released
    assert_smp_high_R9: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> scl_o);

endmodule

// File: tb/tb_sclgen_top.sv
module tb_sclgen_top;

    localparam int OFS  = 4;
    localparam int PMAX = 5;

    typedef struct {
        bit lvl;
        int len;
        int drv;
        int smp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [18:0] wave_cfg = '0;
    logic        scl_o, sample_stb, drive_stb;

    int    errors = 0;
    int    checks = 0;
    int    done_cnt = 0;
    bit    mon_on = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    sclgen_top #(.PRE_MAX(PMAX), .OFFSET(OFS)) dut (
        .clk(clk), .rst(rst), .en(en), .wave_cfg(wave_cfg),
        .scl_o(scl_o), .sample_stb(sample_stb), .drive_stb(drive_stb)
    );

    function automatic int plen(int div, int pre);
        int p;
        p = (pre > PMAX) ? PMAX : pre;
        return (div << p) + OFS;
    endfunction

    function automatic item_t mk(bit lvl, int len);
        item_t it;
        it.lvl = lvl;
        it.len = len;
        it.drv = lvl ? -1 : 1;
        it.smp = lvl ? len / 2 : -1;
        return it;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: measures each SCL run and strobe positions, pops and compares
    bit  in_run = 0;
    bit  cur_lvl;
    int  run_len, drv_pos, smp_pos;
    always @(negedge clk) begin
        if (!mon_on) begin
            in_run = 0;
        end else if (!in_run || scl_o != cur_lvl) begin
            if (in_run && exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                // R1 low length, R2 high length, R8/R9 strobe positions
                chk(cur_lvl == e.lvl, e.lvl ? "R2" : "R1", "phase level", int'(cur_lvl), int'(e.lvl));
                chk(run_len == e.len, e.lvl ? "R2" : "R1", "phase length", run_len, e.len);
                chk(drv_pos == e.drv, "R8", "drive strobe index", drv_pos, e.drv);
                chk(smp_pos == e.smp, "R9", "sample strobe index", smp_pos, e.smp);
                done_cnt++;
            end
            if (in_run || scl_o == 1'b0) begin
                in_run  = 1;
                cur_lvl = scl_o;
                run_len = 1;
                drv_pos = drive_stb  ? 0 : -1;
                smp_pos = sample_stb ? 0 : -1;
            end
        end else begin
            if (drive_stb)  drv_pos = (drv_pos == -1) ? run_len : -2;
            if (sample_stb) smp_pos = (smp_pos == -1) ? run_len : -2;
            run_len++;
        end
    end

    task automatic set_cfg(int lo, int hi, int pre);
        wave_cfg = {3'(pre), 8'(hi), 8'(lo)};
    endtask

    task automatic check_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(scl_o == 1'b1, "R7", "idle scl", int'(scl_o), 1);
            chk(!sample_stb && !drive_stb, "R7", "idle strobes",
                int'({sample_stb, drive_stb}), 0);
        end
    endtask

    task automatic stop_run();
        wait (exp_q.size() == 0);
        @(negedge clk);
        en = 1'b0;
        mon_on = 1'b0;
        check_idle(3);
    endtask

    // Driver: queue alternating phases from the requirements, then run
    task automatic run_case(int lo, int hi, int pre, int nph);
        @(negedge clk);
        set_cfg(lo, hi, pre);
        for (int i = 0; i < nph; i++)
            exp_q.push_back(mk(i[0], i[0] ? plen(hi, pre) : plen(lo, pre)));
        mon_on = 1'b1;
        en = 1'b1;
        stop_run();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs during reset
        chk(scl_o == 1'b1, "R10", "reset scl", int'(scl_o), 1);
        chk(!sample_stb && !drive_stb, "R10", "reset strobes",
            int'({sample_stb, drive_stb}), 0);
        rst = 1'b0;
        check_idle(2);

        // R5 R1 R2 R8 R9: symmetric baseline
        run_case(2, 2, 0, 4);
        // R3: unequal dividers with prescaler distinguish field positions
        run_case(5, 1, 2, 4);
        // R4: prescaler field 7 saturates at 5
        run_case(1, 3, 7, 4);
        // R1 R8 R9: zero dividers, bare offset
        run_case(0, 0, 0, 4);
        // R1: long low phase across counter width
        run_case(255, 3, 5, 2);

        // R6: rewrite mid-phase; phase 3 keeps old length, phase 4 uses new
        @(negedge clk);
        set_cfg(3, 2, 1);
        exp_q.push_back(mk(0, plen(3, 1)));
        exp_q.push_back(mk(1, plen(2, 1)));
        exp_q.push_back(mk(0, plen(3, 1)));
        exp_q.push_back(mk(1, plen(6, 0)));
        exp_q.push_back(mk(0, plen(9, 0)));
        mon_on = 1'b1;
        en = 1'b1;
        wait (done_cnt > 0 && exp_q.size() == 3);
        @(negedge clk);
        set_cfg(9, 6, 0);
        stop_run();

        // R7 R5: disable mid-phase, then re-enable gives a full low phase
        @(negedge clk);
        set_cfg(4, 4, 1);
        en = 1'b1;
        repeat (7) @(negedge clk);
        en = 1'b0;
        check_idle(4);
        exp_q.push_back(mk(0, plen(4, 1)));
        exp_q.push_back(mk(1, plen(4, 1)));
        mon_on = 1'b1;
        en = 1'b1;
        stop_run();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule